// File: doc/BRIEF.md
# Ambient Light Sensor Command Controller

This block is the command interpreter and conversion sequencer placed behind a serial-bus slave front end in an ambient light sensor. The front end handles the wire protocol and passes in start and stop events, each data byte of a matched write transaction, and a pulse each time a read byte has been consumed. The controller decodes one-byte opcodes, holds an 8-bit integration-time register, runs single or repeating conversions at coarse or fine resolution, and latches a 16-bit result that it presents as two read bytes, most significant byte first.

The conversion length is a clock-cycle count. It is the resolution mode's base count scaled by the integration-time register relative to its reset value, using integer arithmetic. The light-to-count path is modelled by a 16-bit count input, which is sampled on the cycle a conversion ends. A single-shot conversion leaves the block powered down. A repeating conversion restarts by itself until a power-down opcode arrives. The block also supplies the 7-bit slave address that the front end matches against, chosen from two values by a strap input.

Top module: `lux_cmd_ctrl`

## Requirements
- R1: After reset, conv_busy is 0, both read bytes are 0x00, and the integration-time register holds 0x45.
- R2: Opcode 01000_xyz (binary) copies xyz into bits 7..5 of the integration-time register and leaves bits 4..0 unchanged.
- R3: Opcode 011_abcde (binary) copies abcde into bits 4..0 of the integration-time register and leaves bits 7..5 unchanged.
- R4: Only the first data byte of a write transaction is taken as an opcode. Later bytes before the next start or stop event have no effect.
- R5: A read returns result bits 15..8 first, then bits 7..0, then 0x00 for any further byte. A start event rewinds to the high byte.
- R6: Opcode 0x23 starts a single-shot fine-resolution conversion and 0x20 starts a single-shot coarse one. conv_busy is high for exactly N cycles after the edge that accepts the opcode. The result is then latched and the block powers down.
- R7: N equals floor(BASE × T / 69), where T is the integration-time value when the conversion starts and BASE is BASE_HI for coarse or BASE_LO for fine. N is never less than 1.
- R8: Opcodes 0x10 (coarse) and 0x13 (fine) run conversions back to back. The result updates at each end. Opcode 0x00 stops the conversions and powers the block down.
- R9: Any opcode other than 0x00, 0x01, 0x07, 0x10, 0x13, 0x20, 0x23, 01000xxx and 011xxxxx changes nothing.
- R10: The result changes only when a conversion ends or on a clear, so a read during a conversion returns the previous value.
- R11: own_addr is 1011100 when addr_sel is 0 and 0100011 when addr_sel is 1.
- R12: rst_n low clears all state at once, without waiting for a clock edge.
- R13: Opcode 0x01 powers the block up. Opcode 0x07 clears the result to 0 when the block is powered and is ignored when it is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_sel | input | 1 | Strap selecting one of two slave addresses |
| own_addr | output | 7 | Slave address for the front end to match |
| bus_start | input | 1 | Start or repeated-start event pulse |
| bus_stop | input | 1 | Stop event pulse |
| rx_valid | input | 1 | Write data byte present for a matched transaction |
| rx_byte | input | 8 | Write data byte |
| tx_req | input | 1 | Current read byte consumed, advance to the next |
| tx_byte | output | 8 | Byte to return on the next read slot |
| adc_count | input | 16 | Modelled light count, sampled at conversion end |
| conv_busy | output | 1 | A conversion is in progress |

## Verification
The bench builds the block with BASE_HI of 40, BASE_LO of 12 and a 12-bit cycle counter, so a default conversion lasts 40 or 12 cycles instead of tens of thousands. This puts every timing corner within a short run: the largest integration-time setting (254 gives 147 cycles), a small one (31 gives 5 cycles on the fine base), and zero, which exercises the minimum-of-one clamp. The shorter counter also keeps the intermediate product width small. A behavioural reference model counts remaining cycles down and is compared against the busy flag, the read byte and the address on every clock. Directed checks measure busy lengths against hand-computed values.

// File: rtl/lux_pkg.sv
package lux_pkg;

    localparam int MT_W     = 8;
    localparam int MT_HI_W  = 3;
    localparam int MT_LO_W  = MT_W - MT_HI_W;
    localparam int RES_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;

    localparam logic [MT_W-1:0]   MT_DEFAULT = 8'b0100_0101;
    localparam logic [ADDR_W-1:0] SLV_ADDR_A = 7'b1011100;
    localparam logic [ADDR_W-1:0] SLV_ADDR_B = 7'b0100011;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_PDOWN,
        CMD_PON,
        CMD_CLR,
        CMD_CONT_H,
        CMD_CONT_L,
        CMD_ONCE_H,
        CMD_ONCE_L,
        CMD_MT_HI,
        CMD_MT_LO
    } cmd_e;

    function automatic cmd_e classify(input logic [BYTE_W-1:0] b);
        cmd_e c;
        casez (b)
            8'b0000_0000: c = CMD_PDOWN;
            8'b0000_0001: c = CMD_PON;
            8'b0000_0111: c = CMD_CLR;
            8'b0001_0000: c = CMD_CONT_H;
            8'b0001_0011: c = CMD_CONT_L;
            8'b0010_0000: c = CMD_ONCE_H;
            8'b0010_0011: c = CMD_ONCE_L;
            8'b0100_0???: c = CMD_MT_HI;
            8'b011?_????: c = CMD_MT_LO;
            default:      c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lux_cmd_dec.sv
module lux_cmd_dec
    import lux_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_start,
    input  logic                  bus_stop,
    input  logic                  rx_valid,
    input  logic [BYTE_W-1:0]     rx_byte,
    output logic                  cmd_stb_o,
    output cmd_e                  cmd_op_o,
    output logic [MT_LO_W-1:0]    cmd_arg_o
);

    typedef struct packed {
        logic taken;
    } dec_st_t;

    localparam dec_st_t DEC_RST = '{taken: 1'b0};

    dec_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        cmd_stb_o = rx_valid && !st_q.taken;
        cmd_op_o  = classify(rx_byte);
        cmd_arg_o = rx_byte[MT_LO_W-1:0];
        if (bus_start || bus_stop) begin
            st_d.taken = 1'b0;
        end else if (rx_valid) begin
            st_d.taken = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DEC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    AST_SINGLE_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb_o && !bus_start && !bus_stop) |=> !cmd_stb_o) else $error("second opcode accepted"); // R4

    AST_SLOT_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !rx_valid) |=> !st_q.taken) else $error("slot not reopened after stop"); // R4

endmodule

// File: rtl/lux_mtime_reg.sv
module lux_mtime_reg
    import lux_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_stb_i,
    input  cmd_e                  cmd_op_i,
    input  logic [MT_LO_W-1:0]    cmd_arg_i,
    output logic [MT_W-1:0]       mtime_o
);

    typedef struct packed {
        logic [MT_HI_W-1:0] hi;
        logic [MT_LO_W-1:0] lo;
    } mt_st_t;

    localparam mt_st_t MT_RST = MT_DEFAULT;

    mt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_stb_i) begin
            if (cmd_op_i == CMD_MT_HI) begin
                st_d.hi = cmd_arg_i[MT_HI_W-1:0];
            end else if (cmd_op_i == CMD_MT_LO) begin
                st_d.lo = cmd_arg_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= MT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mtime_o = st_q;

    AST_MT_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb_i && cmd_op_i == CMD_MT_HI) |=>
        (mtime_o[MT_W-1:MT_LO_W] == $past(cmd_arg_i[MT_HI_W-1:0])) &&
        (mtime_o[MT_LO_W-1:0] == $past(mtime_o[MT_LO_W-1:0]))) else $error("high field load wrong"); // R2

    AST_MT_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb_i && cmd_op_i == CMD_MT_LO) |=>
        (mtime_o[MT_LO_W-1:0] == $past(cmd_arg_i)) &&
        (mtime_o[MT_W-1:MT_LO_W] == $past(mtime_o[MT_W-1:MT_LO_W]))) else $error("low field load wrong"); // R3

    AST_MT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_stb_i && (cmd_op_i == CMD_MT_HI || cmd_op_i == CMD_MT_LO)) |=> $stable(mtime_o)) else $error("register moved without a load"); // R9

endmodule

// File: rtl/lux_conv_seq.sv
module lux_conv_seq
    import lux_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int BASE_HI = 38400,
    parameter int BASE_LO = 5120
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_stb_i,
    input  cmd_e                  cmd_op_i,
    input  logic [MT_W-1:0]       mtime_i,
    input  logic [RES_W-1:0]      adc_count_i,
    output logic                  busy_o,
    output logic [RES_W-1:0]      result_o
);

    localparam int PW = CNT_W + MT_W;

    typedef struct packed {
        logic             pwr;
        logic             act;
        logic             cont;
        logic             hres;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tgt;
        logic [RES_W-1:0] res;
    } seq_st_t;

    localparam seq_st_t SEQ_RST = '{
        pwr: 1'b0, act: 1'b0, cont: 1'b0, hres: 1'b0,
        cnt: '0, tgt: '0, res: '0
    };

    function automatic logic [CNT_W-1:0] ticks(input logic hr, input logic [MT_W-1:0] mt);
        logic [PW-1:0] prod;
        logic [PW-1:0] quo;
        prod = (hr ? PW'(BASE_HI) : PW'(BASE_LO)) * PW'(mt);
        quo  = prod / PW'(MT_DEFAULT);
        if (quo == '0) begin
            quo = PW'(1);
        end
        return CNT_W'(quo);
    endfunction

    seq_st_t st_d, st_q;
    logic    done;
    logic    start;
    logic    start_hres;

    always_comb begin
        st_d       = st_q;
        done       = 1'b0;
        start      = 1'b0;
        start_hres = 1'b0;

        if (st_q.act) begin
            if (st_q.cnt == st_q.tgt - 1'b1) begin
                done     = 1'b1;
                st_d.res = adc_count_i;
                if (st_q.cont) begin
                    st_d.cnt = '0;
                    st_d.tgt = ticks(st_q.hres, mtime_i);
                end else begin
                    st_d.act = 1'b0;
                    st_d.pwr = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (cmd_stb_i) begin
            unique case (cmd_op_i)
                CMD_PDOWN: begin
                    st_d.pwr  = 1'b0;
                    st_d.act  = 1'b0;
                    st_d.cont = 1'b0;
                end
                CMD_PON: st_d.pwr = 1'b1;
                CMD_CLR: begin
                    if (st_q.pwr) begin
                        st_d.res = '0;
                    end
                end
                CMD_CONT_H: begin start = 1'b1; start_hres = 1'b1; st_d.cont = 1'b1; end
                CMD_CONT_L: begin start = 1'b1; start_hres = 1'b0; st_d.cont = 1'b1; end
                CMD_ONCE_H: begin start = 1'b1; start_hres = 1'b1; st_d.cont = 1'b0; end
                CMD_ONCE_L: begin start = 1'b1; start_hres = 1'b0; st_d.cont = 1'b0; end
                default: ;
            endcase
        end

        if (start) begin
            st_d.pwr  = 1'b1;
            st_d.act  = 1'b1;
            st_d.hres = start_hres;
            st_d.cnt  = '0;
            st_d.tgt  = ticks(start_hres, mtime_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.act;
    assign result_o = st_q.res;

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act |-> (st_q.cnt < st_q.tgt)) else $error("counter beyond target"); // R7

    AST_TGT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act |-> (st_q.tgt != '0)) else $error("zero-length conversion"); // R7

    AST_BUSY_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act |-> st_q.pwr) else $error("converting while powered down"); // R6

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !(cmd_stb_i && cmd_op_i == CMD_CLR)) |=> $stable(result_o)) else $error("result moved mid-conversion"); // R10

    AST_ONESHOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !st_q.cont && !cmd_stb_i) |=> (!busy_o && !st_q.pwr)) else $error("single shot did not power down"); // R6

endmodule

// File: rtl/lux_rd_port.sv
module lux_rd_port
    import lux_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_start,
    input  logic                  tx_req,
    input  logic [RES_W-1:0]      result_i,
    output logic [BYTE_W-1:0]     tx_byte_o
);

    localparam int NBYTES = RES_W / BYTE_W;
    localparam int IDX_W  = $clog2(NBYTES + 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } rd_st_t;

    localparam rd_st_t RD_RST = '{idx: '0};

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_start) begin
            st_d.idx = '0;
        end else if (tx_req && st_q.idx != IDX_W'(NBYTES)) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RD_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        tx_byte_o = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (st_q.idx == IDX_W'(i)) begin
                tx_byte_o = result_i[RES_W-1-i*BYTE_W -: BYTE_W];
            end
        end
    end

    AST_RD_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (st_q.idx == '0)) else $error("start did not rewind"); // R5

    AST_RD_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx == IDX_W'(NBYTES) && !bus_start) |=> (tx_byte_o == '0)) else $error("filler byte not zero"); // R5

endmodule

// File: rtl/lux_cmd_ctrl.sv
module lux_cmd_ctrl
    import lux_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int BASE_HI = 38400,
    parameter int BASE_LO = 5120
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  addr_sel,
    output logic [ADDR_W-1:0]     own_addr,
    input  logic                  bus_start,
    input  logic                  bus_stop,
    input  logic                  rx_valid,
    input  logic [BYTE_W-1:0]     rx_byte,
    input  logic                  tx_req,
    output logic [BYTE_W-1:0]     tx_byte,
    input  logic [RES_W-1:0]      adc_count,
    output logic                  conv_busy
);

    logic                 cmd_stb;
    cmd_e                 cmd_op;
    logic [MT_LO_W-1:0]   cmd_arg;
    logic [MT_W-1:0]      mtime;
    logic [RES_W-1:0]     result;

    assign own_addr = addr_sel ? SLV_ADDR_B : SLV_ADDR_A;

    lux_cmd_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .cmd_stb_o (cmd_stb),
        .cmd_op_o  (cmd_op),
        .cmd_arg_o (cmd_arg)
    );

    lux_mtime_reg u_mt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_stb_i (cmd_stb),
        .cmd_op_i  (cmd_op),
        .cmd_arg_i (cmd_arg),
        .mtime_o   (mtime)
    );

    lux_conv_seq #(
        .CNT_W   (CNT_W),
        .BASE_HI (BASE_HI),
        .BASE_LO (BASE_LO)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_stb_i   (cmd_stb),
        .cmd_op_i    (cmd_op),
        .mtime_i     (mtime),
        .adc_count_i (adc_count),
        .busy_o      (conv_busy),
        .result_o    (result)
    );

    lux_rd_port u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .tx_req    (tx_req),
        .result_i  (result),
        .tx_byte_o (tx_byte)
    );

    AST_ADDR_FOLLOWS_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(addr_sel) |-> (own_addr != $past(own_addr))) else $error("address ignored strap"); // R11

endmodule

// File: tb/sim_lux_cmd_ctrl.sv
module sim_lux_cmd_ctrl;

    localparam int CLK_PER = 10;
    localparam int TB_HI   = 40;
    localparam int TB_LO   = 12;
    localparam int TB_CNTW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        addr_sel = 1'b0;
    logic        bus_start = 1'b0;
    logic        bus_stop = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_req = 1'b0;
    logic [15:0] adc_count = 16'h1234;
    logic [6:0]  own_addr;
    logic [7:0]  tx_byte;
    logic        conv_busy;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    lux_cmd_ctrl #(.CNT_W(TB_CNTW), .BASE_HI(TB_HI), .BASE_LO(TB_LO)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .own_addr(own_addr),
        .bus_start(bus_start), .bus_stop(bus_stop), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .tx_byte(tx_byte),
        .adc_count(adc_count), .conv_busy(conv_busy)
    );

    always #(CLK_PER/2) clk = ~clk;

    always @(negedge clk) adc_count <= adc_count + 16'h0137;

    // behavioural reference model
    logic [7:0]  m_mt = 8'h45;
    logic [15:0] m_res = 16'h0000;
    bit          m_pwr = 0, m_act = 0, m_cont = 0, m_hres = 0, m_taken = 0;
    int          m_rem = 0;
    int          m_rd = 0;

    function automatic int ref_ticks(bit hr, logic [7:0] mt);
        int t;
        t = ((hr ? TB_HI : TB_LO) * int'(mt)) / 69;
        if (t < 1) t = 1;
        return t;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mt = 8'h45; m_res = 16'h0; m_pwr = 0; m_act = 0; m_cont = 0;
            m_hres = 0; m_taken = 0; m_rem = 0; m_rd = 0;
        end else begin
            bit         acc;
            bit         pwr_before;
            logic [7:0] b;
            acc = rx_valid && !m_taken;
            b = rx_byte;
            pwr_before = m_pwr;
            if (bus_start) m_rd = 0;
            else if (tx_req && m_rd < 2) m_rd++;
            if (bus_start || bus_stop) m_taken = 0;
            else if (rx_valid) m_taken = 1;
            if (m_act) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_res = adc_count;
                    if (m_cont) m_rem = ref_ticks(m_hres, m_mt);
                    else begin m_act = 0; m_pwr = 0; end
                end
            end
            if (acc) begin
                if (b == 8'h00) begin m_pwr = 0; m_act = 0; m_cont = 0; end
                else if (b == 8'h01) m_pwr = 1;
                else if (b == 8'h07) begin if (pwr_before) m_res = 16'h0; end
                else if (b == 8'h10 || b == 8'h13 || b == 8'h20 || b == 8'h23) begin
                    m_pwr = 1; m_act = 1;
                    m_cont = (b[7:4] == 4'h1);
                    m_hres = (b[1:0] == 2'b00);
                    m_rem = ref_ticks(m_hres, m_mt);
                end
                else if (b[7:3] == 5'b01000) m_mt = {b[2:0], m_mt[4:0]};
                else if (b[7:5] == 3'b011) m_mt = {m_mt[7:5], b[4:0]};
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison and busy-run measurement
    int run_len = 0;
    int last_len = -1;
    always @(negedge clk) begin
        logic [7:0] exp_tx;
        #(CLK_PER/4);
        exp_tx = (m_rd == 0) ? m_res[15:8] : (m_rd == 1) ? m_res[7:0] : 8'h00;
        chk({cur_req, " busy"}, int'(conv_busy), int'(m_act));
        chk({cur_req, " tx_byte"}, int'(tx_byte), int'(exp_tx));
        chk("R11 own_addr", int'(own_addr), addr_sel ? 7'b0100011 : 7'b1011100);
        if (conv_busy) run_len++;
        else begin
            if (run_len != 0) last_len = run_len;
            run_len = 0;
        end
    end

    task automatic send_op(input logic [7:0] b);
        @(negedge clk); bus_start = 1;
        @(negedge clk); bus_start = 0; rx_valid = 1; rx_byte = b;
        @(negedge clk); rx_valid = 0; bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask

    task automatic send_two(input logic [7:0] b1, input logic [7:0] b2);
        @(negedge clk); bus_start = 1;
        @(negedge clk); bus_start = 0; rx_valid = 1; rx_byte = b1;
        @(negedge clk); rx_byte = b2;
        @(negedge clk); rx_valid = 0; bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask

    task automatic read_word(output logic [15:0] w);
        logic [7:0] extra;
        @(negedge clk); bus_start = 1;
        @(negedge clk); bus_start = 0;
        #(CLK_PER/4 + 1); w[15:8] = tx_byte;
        @(negedge clk); tx_req = 1;
        @(negedge clk); tx_req = 0;
        #(CLK_PER/4 + 1); w[7:0] = tx_byte;
        @(negedge clk); tx_req = 1;
        @(negedge clk); tx_req = 0;
        #(CLK_PER/4 + 1); extra = tx_byte;
        chk("R5 filler byte", int'(extra), 0);
        @(negedge clk); bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask

    task automatic timed_conv(input logic [7:0] op, input int exp_len, input string req);
        int guard;
        last_len = -1;
        send_op(op);
        guard = 0;
        do begin
            @(negedge clk); #(CLK_PER/4 + 1);
            guard++;
        end while (conv_busy && guard < 1000);
        chk(req, last_len, exp_len);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w, prev, a;
        #1 rst_n = 0;
        idle(3);
        rst_n = 1;
        idle(2);

        cur_req = "R1";
        #(CLK_PER/4 + 1);
        chk("R1 busy after reset", int'(conv_busy), 0);
        read_word(w);
        chk("R1 result after reset", int'(w), 0);
        timed_conv(8'h20, 40, "R1 default integration time");

        cur_req = "R11";
        addr_sel = 1; idle(2);
        chk("R11 alternate address", int'(own_addr), 7'h23);
        addr_sel = 0; idle(2);
        chk("R11 primary address", int'(own_addr), 7'h5C);

        cur_req = "R6";
        timed_conv(8'h23, 12, "R6 single fine length");
        read_word(prev);
        chk("R6 result latched", int'(prev), int'(m_res));
        chk("R5 high byte first", int'(prev[15:8]), int'(m_res[15:8]));

        cur_req = "R10";
        send_op(8'h20); idle(3);
        read_word(w);
        chk("R10 read mid-conversion", int'(w), int'(prev));
        idle(45);
        chk("R6 powered down after single", int'(conv_busy), 0);

        cur_req = "R13";
        read_word(prev);
        send_op(8'h07); idle(2);
        read_word(w);
        chk("R13 clear ignored when off", int'(w), int'(prev));
        send_op(8'h01); send_op(8'h07); idle(2);
        read_word(w);
        chk("R13 clear when powered", int'(w), 0);

        cur_req = "R2";
        send_op(8'h47);
        cur_req = "R3";
        send_op(8'h7E);
        timed_conv(8'h20, 147, "R7 R2 R3 integration 254 coarse");
        send_op(8'h40); send_op(8'h7F);
        timed_conv(8'h23, 5, "R7 integration 31 fine");
        send_op(8'h60);
        timed_conv(8'h23, 1, "R7 integration zero clamps to one");

        cur_req = "R4";
        send_two(8'h42, 8'h23); idle(3);
        chk("R4 second opcode ignored", int'(conv_busy), 0);
        send_two(8'h65, 8'h7F);
        timed_conv(8'h23, 12, "R4 second load ignored");

        cur_req = "R9";
        read_word(prev);
        send_op(8'h05); send_op(8'h48); send_op(8'h30); send_op(8'hFF); send_op(8'h02);
        chk("R9 undefined opcodes idle", int'(conv_busy), 0);
        read_word(w);
        chk("R9 result untouched", int'(w), int'(prev));
        timed_conv(8'h23, 12, "R9 integration untouched");

        cur_req = "R8";
        send_op(8'h13);
        idle(40);
        chk("R8 still converting", int'(conv_busy), 1);
        read_word(a);
        idle(13);
        read_word(w);
        n_vec++;
        if (a == w) begin
            n_bad++;
            $display("FAIL R8: got 0x%0h expected a change from 0x%0h", w, a);
        end
        send_op(8'h00); idle(2);
        chk("R8 power-down stops", int'(conv_busy), 0);

        cur_req = "R12";
        send_op(8'h47);
        send_op(8'h10); idle(5);
        @(negedge clk); #(CLK_PER/8); rst_n = 0;
        #(CLK_PER/4);
        chk("R12 busy cleared asynchronously", int'(conv_busy), 0);
        chk("R12 read byte cleared", int'(tx_byte), 0);
        idle(3); rst_n = 1; idle(1);
        timed_conv(8'h20, 40, "R12 integration restored");

        idle(3);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule